// File: doc/BRIEF.md
# Ternary Processor-Mask Decoder with Enable-Vector Register

Each control unit in a partitionable array drives a fixed group of processing elements. This block turns a compact ternary mask word into the enable pattern for that group. Every address position in the mask may demand a 0, demand a 1, or accept either value. The mask word also has a polarity bit, so a negative mask enables exactly the elements that the positive form would leave off. The address positions split into two fields. The upper field is compared against the index of each element within the group. The lower field is compared against the physical address of the control unit itself. An element is selected only when both fields match.

The decoded pattern is not sent out directly. It is written into an enable-vector register, and that register can be rewritten in several ways: from the decoder, from a raw vector supplied by the caller, by merging with either source through OR or AND, or by inverting itself. This lets a sequence of masks build up an arbitrary set of enabled elements. The registered vector is the only output. Bit j of the vector enables element j of the group.

Top module: `mask_enable_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `enable_vec` becomes all zeros.
- R2: When `load` is low at a rising edge, `enable_vec` keeps its value, whatever the other inputs are.
- R3: The decoded bit j is set when, for every group position k (0 = least significant), the 2-bit code at `mask_word[8+2k+1 : 8+2k]` accepts bit k of j. Code 00 accepts only 0, code 01 accepts only 1, and codes 10 and 11 accept both values.
- R4: Each controller position k uses the code at `mask_word[2k+1 : 2k]`, with the same code values as R3, and is checked against `ctrl_addr[k]`. If any controller position rejects `ctrl_addr`, every decoded bit of a positive mask is 0.
- R5: When `mask_word[20]` is 1, every decoded bit is the complement of the bit that the positive mask would give.
- R6: `op_sel` = 0 with `load` high writes the decoded vector into `enable_vec` at the next edge.
- R7: `op_sel` = 1 with `load` high writes `raw_vec` into `enable_vec`. `mask_word` and `ctrl_addr` have no effect on the result.
- R8: `op_sel` = 2 ORs the decoded vector into `enable_vec`, and `op_sel` = 3 ANDs the decoded vector into it.
- R9: `op_sel` = 4 ORs `raw_vec` into `enable_vec`, and `op_sel` = 5 ANDs `raw_vec` into it.
- R10: `op_sel` = 6 replaces `enable_vec` with its own bitwise complement.
- R11: `op_sel` = 7 with `load` high leaves `enable_vec` unchanged.
- R12: A positive mask in which every position holds a don't-care code enables all 64 elements. A group field that requires an exact index i gives a vector with only bit i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mask_word | input | 21 | Bit 20 is polarity, bits 19:8 hold the group field, bits 7:0 hold the controller field |
| ctrl_addr | input | 4 | Physical address of this control unit |
| op_sel | input | 3 | Update operation applied to the vector register |
| load | input | 1 | Strobe that applies `op_sel` at the next edge |
| raw_vec | input | 64 | Raw vector operand |
| enable_vec | output | 64 | Registered enable vector, bit j for element j |

## Verification
On every cycle, the bound assertions check the register-update rules. These cover holding while `load` is low, the raw load, OR and AND with the raw vector, inversion, and the no-op code. They also check two decoder boundaries: a controller-address mismatch must clear a positive mask, and an all-don't-care positive mask must set every bit. The ternary match of individual group positions, the polarity inversion of mixed patterns, and merges with decoded vectors are only visible through the bench. It drives specific index patterns and a long run of randomized mask words and operations against a behavioural model that is compared on every clock.

// File: rtl/mask_dec_pkg.sv
package mask_dec_pkg;

    localparam int ADDR_W_DEF = 10;
    localparam int CTRL_W_DEF = 4;

    typedef enum logic [2:0] {
        OP_LD_DEC  = 3'd0,
        OP_LD_RAW  = 3'd1,
        OP_OR_DEC  = 3'd2,
        OP_AND_DEC = 3'd3,
        OP_OR_RAW  = 3'd4,
        OP_AND_RAW = 3'd5,
        OP_INVERT  = 3'd6,
        OP_NOP     = 3'd7
    } vec_op_e;

    typedef enum logic [2:0] {
        K_ASSIGN,
        K_OR,
        K_AND,
        K_INVERT,
        K_HOLD
    } combine_e;

    typedef struct packed {
        logic     src_raw;
        combine_e kind;
    } op_info_t;

    function automatic op_info_t decode_op(vec_op_e op);
        op_info_t r;
        r.src_raw = 1'b0;
        r.kind    = K_HOLD;
        case (op)
            OP_LD_DEC:  begin r.src_raw = 1'b0; r.kind = K_ASSIGN; end
            OP_LD_RAW:  begin r.src_raw = 1'b1; r.kind = K_ASSIGN; end
            OP_OR_DEC:  begin r.src_raw = 1'b0; r.kind = K_OR;     end
            OP_AND_DEC: begin r.src_raw = 1'b0; r.kind = K_AND;    end
            OP_OR_RAW:  begin r.src_raw = 1'b1; r.kind = K_OR;     end
            OP_AND_RAW: begin r.src_raw = 1'b1; r.kind = K_AND;    end
            OP_INVERT:  begin r.src_raw = 1'b0; r.kind = K_INVERT; end
            default:    begin r.src_raw = 1'b0; r.kind = K_HOLD;   end
        endcase
        return r;
    endfunction

    // One ternary position: upper code bit means "accept either value",
    // otherwise the lower code bit must equal the address bit.
    function automatic logic tern_accepts(logic [1:0] code, logic addr_bit);
        return code[1] | (code[0] == addr_bit);
    endfunction

endpackage

// File: rtl/mask_field_match.sv
module mask_field_match #(
    parameter int POS = 4
) (
    input  logic [2*POS-1:0] codes,
    input  logic [POS-1:0]   value,
    output logic             hit
);
    import mask_dec_pkg::*;

    logic [POS-1:0] pos_ok;

    genvar k;
    generate
        for (k = 0; k < POS; k++) begin : g_pos
            assign pos_ok[k] = tern_accepts(codes[2*k +: 2], value[k]);
        end
    endgenerate

    assign hit = &pos_ok;

endmodule

// File: rtl/mask_decoder.sv
module mask_decoder #(
    parameter int GRP_W  = 6,
    parameter int CTRL_W = 4,
    localparam int VEC_W = 1 << GRP_W
) (
    input  logic [2*GRP_W-1:0]  grp_codes,
    input  logic [2*CTRL_W-1:0] ctrl_codes,
    input  logic                neg,
    input  logic [CTRL_W-1:0]   ctrl_addr,
    output logic [VEC_W-1:0]    dec_vec
);
    logic             ctrl_hit;
    logic [VEC_W-1:0] grp_hit;

    mask_field_match #(.POS(CTRL_W)) u_ctrl_match (
        .codes (ctrl_codes),
        .value (ctrl_addr),
        .hit   (ctrl_hit)
    );

    genvar j;
    generate
        for (j = 0; j < VEC_W; j++) begin : g_elem
            localparam logic [GRP_W-1:0] IDX = GRP_W'(j);
            mask_field_match #(.POS(GRP_W)) u_grp_match (
                .codes (grp_codes),
                .value (IDX),
                .hit   (grp_hit[j])
            );
            assign dec_vec[j] = (grp_hit[j] & ctrl_hit) ^ neg;
        end
    endgenerate

endmodule

// File: rtl/mask_vector_reg.sv
module mask_vector_reg #(
    parameter int VEC_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  mask_dec_pkg::vec_op_e     op,
    input  logic [VEC_W-1:0]          dec_vec,
    input  logic [VEC_W-1:0]          raw_vec,
    output logic [VEC_W-1:0]          vec_q
);
    import mask_dec_pkg::*;

    op_info_t         info;
    logic [VEC_W-1:0] operand;
    logic [VEC_W-1:0] vec_d;

    always_comb begin
        info    = decode_op(op);
        operand = info.src_raw ? raw_vec : dec_vec;
        case (info.kind)
            K_ASSIGN: vec_d = operand;
            K_OR:     vec_d = vec_q | operand;
            K_AND:    vec_d = vec_q & operand;
            K_INVERT: vec_d = ~vec_q;
            default:  vec_d = vec_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (load) begin
            vec_q <= vec_d;
        end
    end

endmodule

// File: rtl/mask_enable_unit.sv
module mask_enable_unit #(
    parameter int ADDR_W  = mask_dec_pkg::ADDR_W_DEF,
    parameter int CTRL_W  = mask_dec_pkg::CTRL_W_DEF,
    localparam int GRP_W  = ADDR_W - CTRL_W,
    localparam int VEC_W  = 1 << GRP_W,
    localparam int WORD_W = 2 * ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mask_word,
    input  logic [CTRL_W-1:0] ctrl_addr,
    input  logic [2:0]        op_sel,
    input  logic              load,
    input  logic [VEC_W-1:0]  raw_vec,
    output logic [VEC_W-1:0]  enable_vec
);
    import mask_dec_pkg::*;

    logic [VEC_W-1:0] dec_vec;

    mask_decoder #(.GRP_W(GRP_W), .CTRL_W(CTRL_W)) u_dec (
        .grp_codes  (mask_word[WORD_W-2 -: 2*GRP_W]),
        .ctrl_codes (mask_word[2*CTRL_W-1:0]),
        .neg        (mask_word[WORD_W-1]),
        .ctrl_addr  (ctrl_addr),
        .dec_vec    (dec_vec)
    );

    mask_vector_reg #(.VEC_W(VEC_W)) u_vreg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .op      (vec_op_e'(op_sel)),
        .dec_vec (dec_vec),
        .raw_vec (raw_vec),
        .vec_q   (enable_vec)
    );

endmodule

// File: rtl/mask_enable_unit_chk.sv
module mask_enable_unit_chk #(
    parameter int ADDR_W  = 10,
    parameter int CTRL_W  = 4,
    localparam int GRP_W  = ADDR_W - CTRL_W,
    localparam int VEC_W  = 1 << GRP_W,
    localparam int WORD_W = 2 * ADDR_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] mask_word,
    input logic [CTRL_W-1:0] ctrl_addr,
    input logic [2:0]        op_sel,
    input logic              load,
    input logic [VEC_W-1:0]  raw_vec,
    input logic [VEC_W-1:0]  enable_vec
);
    logic ctrl_reject;
    logic all_dc;

    always_comb begin
        ctrl_reject = 1'b0;
        for (int k = 0; k < CTRL_W; k++) begin
            if (!mask_word[2*k+1] && (mask_word[2*k] != ctrl_addr[k]))
                ctrl_reject = 1'b1;
        end
        all_dc = 1'b1;
        for (int k = 0; k < ADDR_W; k++) begin
            if (!mask_word[2*k+1]) all_dc = 1'b0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $fell(rst) |-> (enable_vec == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(enable_vec));

    assert_ctrl_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd0 && !mask_word[WORD_W-1] && ctrl_reject)
        |=> (enable_vec == '0));

    assert_raw_load_R7: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd1) |=> (enable_vec == $past(raw_vec)));

    assert_raw_or_R9: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd4)
        |=> (enable_vec == ($past(enable_vec) | $past(raw_vec))));

    assert_raw_and_R9: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd5)
        |=> (enable_vec == ($past(enable_vec) & $past(raw_vec))));

    assert_invert_R10: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd6) |=> (enable_vec == ~$past(enable_vec)));

    assert_nop_R11: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd7) |=> $stable(enable_vec));

    assert_all_dc_R12: assert property (@(posedge clk) disable iff (rst)
        (load && op_sel == 3'd0 && !mask_word[WORD_W-1] && all_dc)
        |=> (enable_vec == '1));

endmodule

bind mask_enable_unit mask_enable_unit_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mask_word  (mask_word),
    .ctrl_addr  (ctrl_addr),
    .op_sel     (op_sel),
    .load       (load),
    .raw_vec    (raw_vec),
    .enable_vec (enable_vec)
);

// File: tb/mask_enable_unit_test.sv
module mask_enable_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] mask_word = '0;
    logic [3:0]  ctrl_addr = '0;
    logic [2:0]  op_sel = '0;
    logic        load = 1'b0;
    logic [63:0] raw_vec = '0;
    logic [63:0] enable_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] model = '0;

    always #2 clk = ~clk;

    mask_enable_unit uut (
        .clk        (clk),
        .rst        (rst),
        .mask_word  (mask_word),
        .ctrl_addr  (ctrl_addr),
        .op_sel     (op_sel),
        .load       (load),
        .raw_vec    (raw_vec),
        .enable_vec (enable_vec)
    );

    function automatic logic [63:0] ref_decode(logic [20:0] w, logic [3:0] ca);
        logic [63:0] r;
        bit cm = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (w[2*k+1] == 1'b0 && w[2*k] != ca[k]) cm = 1'b0;
        end
        for (int j = 0; j < 64; j++) begin
            bit pm = 1'b1;
            for (int k = 0; k < 6; k++) begin
                if (w[8+2*k+1] == 1'b0 && w[8+2*k] != ((j >> k) & 1)) pm = 1'b0;
            end
            r[j] = (pm & cm) ^ w[20];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive one cycle from a falling edge, advance the model at the rising
    // edge, compare at the next falling edge.
    task automatic step(string tag, logic ld, logic [2:0] op, logic [20:0] w,
                        logic [3:0] ca, logic [63:0] raw);
        logic [63:0] dv;
        load = ld; op_sel = op; mask_word = w; ctrl_addr = ca; raw_vec = raw;
        @(posedge clk);
        dv = ref_decode(w, ca);
        if (ld) begin
            case (op)
                3'd0: model = dv;
                3'd1: model = raw;
                3'd2: model = model | dv;
                3'd3: model = model & dv;
                3'd4: model = model | raw;
                3'd5: model = model & raw;
                3'd6: model = ~model;
                default: model = model;
            endcase
        end
        @(negedge clk);
        check(tag, enable_vec, model);
    endtask

    localparam logic [20:0] W_ALL_DC = 21'h0FFFFF;
    localparam logic [20:0] W_IDX5   = {1'b0, 12'h011, 8'hFF};
    localparam logic [20:0] W_IDX01  = {1'b0, 12'h002, 8'hFF};
    localparam logic [20:0] W_ODD    = {1'b0, 12'hFFD, 8'hFF};
    localparam logic [20:0] W_CTRL0  = {1'b0, 12'hFFF, 8'hFC};
    localparam logic [20:0] W_CTRL1  = {1'b0, 12'hFFF, 8'hFD};
    localparam logic [63:0] RAW_A    = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] ODD_BITS = 64'hAAAA_AAAA_AAAA_AAAA;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", enable_vec, 64'h0);
        rst = 1'b0;

        step("R12 all dont-care", 1'b1, 3'd0, W_ALL_DC, 4'h3, '0);
        check("R12 all ones", enable_vec, '1);
        step("R2 idle hold", 1'b0, 3'd1, W_IDX5, 4'h3, RAW_A);
        check("R2 unchanged", enable_vec, '1);
        step("R12 exact index", 1'b1, 3'd0, W_IDX5, 4'h3, '0);
        check("R12 only bit 5", enable_vec, 64'h20);
        step("R3 low pos dc", 1'b1, 3'd0, W_IDX01, 4'h3, '0);
        check("R3 bits 0,1", enable_vec, 64'h3);
        step("R3 odd", 1'b1, 3'd0, W_ODD, 4'h3, '0);
        check("R3 odd indices", enable_vec, ODD_BITS);
        step("R4 ctrl reject", 1'b1, 3'd0, W_CTRL0, 4'h5, '0);
        check("R4 zero", enable_vec, 64'h0);
        step("R4 ctrl accept", 1'b1, 3'd0, W_CTRL1, 4'h5, '0);
        check("R4 all ones", enable_vec, '1);
        step("R5 neg reject", 1'b1, 3'd0, {1'b1, W_CTRL0[19:0]}, 4'h5, '0);
        check("R5 all ones", enable_vec, '1);
        step("R5 neg index", 1'b1, 3'd0, {1'b1, W_IDX5[19:0]}, 4'h3, '0);
        check("R5 not bit 5", enable_vec, ~64'h20);
        step("R7 raw load", 1'b1, 3'd1, W_CTRL0, 4'h5, RAW_A);
        check("R7 raw", enable_vec, RAW_A);
        step("R8 and dec", 1'b1, 3'd3, W_ODD, 4'h0, '0);
        check("R8 and", enable_vec, RAW_A & ODD_BITS);
        step("R8 or dec", 1'b1, 3'd2, W_IDX01, 4'h0, '0);
        check("R8 or", enable_vec, (RAW_A & ODD_BITS) | 64'h3);
        step("R10 invert", 1'b1, 3'd6, W_ALL_DC, 4'h0, '0);
        check("R10 inv", enable_vec, ~((RAW_A & ODD_BITS) | 64'h3));
        step("R11 nop", 1'b1, 3'd7, W_ALL_DC, 4'h0, '1);
        check("R11 hold", enable_vec, ~((RAW_A & ODD_BITS) | 64'h3));
        step("R9 and raw", 1'b1, 3'd5, W_ALL_DC, 4'h0, 64'hFFFF_0000_FFFF_0000);
        check("R9 and", enable_vec, ~((RAW_A & ODD_BITS) | 64'h3) & 64'hFFFF_0000_FFFF_0000);
        step("R9 or raw", 1'b1, 3'd4, W_ALL_DC, 4'h0, 64'h1);
        check("R9 or", enable_vec, (~((RAW_A & ODD_BITS) | 64'h3) & 64'hFFFF_0000_FFFF_0000) | 64'h1);
        step("R6 decode load", 1'b1, 3'd0, W_IDX5, 4'h9, '0);
        check("R6 decoded", enable_vec, 64'h20);

        for (int i = 0; i < 500; i++) begin
            logic [20:0] w;
            for (int k = 0; k < 10; k++) begin
                w[2*k +: 2] = 2'($urandom_range(0, 3));
            end
            w[20] = 1'($urandom_range(0, 1));
            step("R3 random", ($urandom_range(0, 9) < 8), 3'($urandom_range(0, 7)),
                 w, 4'($urandom_range(0, 15)), {$urandom, $urandom});
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset again", enable_vec, 64'h0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule